// File: doc/BRIEF.md
# Shared PHY Power Sequencer

This block arbitrates power requests from up to four lane users of a single PHY and controls that PHY's reset and per-lane idle state. A shared count records how many lanes currently hold the PHY powered. The PHY reset is released only when the count goes from zero to one. When the count returns to zero, the reset is asserted again.

The first power-on runs a bring-up handshake through a configuration bridge. That bridge is outside this block, and the block reaches it through two request ports:

- a command port that either selects an internal address or writes a small value to it;
- a status read port that returns a 16-bit status word.

The handshake has three polled phases:

1. Wait for PLL lock.
2. Reprogram the clocking and wait for the PLL output flag to clear.
3. Wait for the PLL to relock.

All three phases draw on one cycle budget. On failure, every change made for that request is undone.

Requests are served one at a time. Each finished request raises a one-cycle done pulse on the requesting lane and presents a result code beside it.

Both bridge ports use valid/ready handshakes:

- **Command port.** The block holds `cmd_valid` and the command fields unchanged until `cmd_ready` is high at a clock edge. The bridge may stall for any number of cycles.
- **Read port.** `rd_valid` is held until `rd_ready` is seen. The bridge then returns exactly one `rsp_valid` beat carrying the status word. There is no back-pressure on the response.

A requester holds its request line high until it sees its done bit, and drops it during that same cycle. No grant is made in a cycle where done is high.

Top module: `phy_pwr_seq`

## Requirements
- R1: While reset is applied and right after it, `phy_reset` is 1, every `lane_idle` bit is 1, and `req_done`, `cmd_valid` and `rd_valid` are all 0.
- R2: A power-on that finds the count at zero sets the count to 1, releases `phy_reset` and starts the bring-up handshake. A power-on at a nonzero count increments the count and completes with no bridge traffic, with result 0 and `lane_idle` unchanged. The bridge is never addressed while `phy_reset` is 1.
- R3: The handshake issues exactly these commands, in this order:
  1. select address 0x10 (`cmd_write`=0, data 0);
  2. write 0x8 to address 0x10;
  3. write 0x8 to address 0x12;
  4. select address 0x10.

  The first command appears in the cycle after reset release. The requesting lane's idle bit clears when that first select is accepted.
- R4: The first and third phases pass when status bit 9 reads 1. The second phase passes when status bit 10 reads 0. After three passing phases the request completes with result 0.
- R5: After a status response that does not pass, the next read request comes no sooner than `POLL_CYC` cycles later.
- R6: One budget of `BUDGET_CYC` cycles starts at reset release and covers all three phases. A phase that is due for a read after the budget has run out fails instead of reading.
- R7: On failure, `phy_reset` returns to 1, the count returns to its previous value and the lane's idle bit is set again. The result is 1 for a failure in the first or third phase and 2 for a failure in the second phase.
- R8: A power-off sets that lane's idle bit and decrements the count, with result 0. `phy_reset` is asserted only when the count reaches zero. A power-off at count zero leaves the count and `phy_reset` unchanged.
- R9: Lane 0 has the highest priority and lane 3 the lowest. If one lane raises both requests at once, the power-on is served.
- R10: `req_done` is one-hot or zero, and never high in two consecutive cycles.
- R11: While `cmd_valid` waits for `cmd_ready`, the command fields stay stable. While `rd_valid` waits for `rd_ready`, it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_req | input | NLANE | Per-lane power-on request, held until done |
| pwr_off_req | input | NLANE | Per-lane power-off request, held until done |
| req_done | output | NLANE | One-cycle completion pulse for the served lane |
| req_err | output | 2 | Result with done: 0 ok, 1 lock timeout, 2 output-flag timeout |
| phy_reset | output | 1 | PHY reset, 1 = held in reset |
| lane_idle | output | NLANE | Per-lane idle control, 1 = idle |
| cmd_valid | output | 1 | Command request valid |
| cmd_ready | input | 1 | Bridge accepts command |
| cmd_write | output | 1 | 1 = write data to address, 0 = select address only |
| cmd_addr | output | ADDR_W | Internal PHY address |
| cmd_data | output | DATA_W | Write value |
| rd_valid | output | 1 | Status read request valid |
| rd_ready | input | 1 | Bridge accepts read |
| rsp_valid | input | 1 | Status response beat |
| rsp_data | input | STAT_W | Status word |

## Verification
The checker assumes four things about the environment:

- the bridge answers each accepted read with exactly one response beat, and only while a read is outstanding;
- `cmd_ready` may stall for any number of cycles;
- requesters hold a request until done and drop it in the done cycle;
- no lane powers on twice without a power-off in between.

The bench models the bridge as a responder that produces one beat in the cycle after a read is accepted. Its `cmd_ready` follows a fixed pattern that stalls one cycle in four. Every request is released in the cycle its done bit is observed.

// File: rtl/phy_pwr_pkg.sv
package phy_pwr_pkg;

  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_LOCK   = 2'd1,
    RES_OUTFLG = 2'd2
  } res_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SEL,
    S_WR_A,
    S_WR_B,
    S_CHK,
    S_RD,
    S_RSP,
    S_GAP
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_LOCK,
    PH_OUT,
    PH_RELOCK
  } phase_e;

endpackage

// File: rtl/pwr_req_arb.sv
module pwr_req_arb #(
  parameter int NLANE  = 4,
  parameter int LANE_W = 2
) (
  input  logic              en,
  input  logic [NLANE-1:0]  on_req,
  input  logic [NLANE-1:0]  off_req,
  output logic              gnt_vld,
  output logic [LANE_W-1:0] gnt_lane,
  output logic              gnt_on
);
  // lowest index wins: scan from the top so lower lanes overwrite
  always_comb begin
    gnt_vld  = 1'b0;
    gnt_lane = '0;
    gnt_on   = 1'b0;
    for (int i = NLANE - 1; i >= 0; i--) begin
      if (en && (on_req[i] || off_req[i])) begin
        gnt_vld  = 1'b1;
        gnt_lane = LANE_W'(i);
        gnt_on   = on_req[i];
      end
    end
  end
endmodule

// File: rtl/pwr_seq_timers.sv
module pwr_seq_timers #(
  parameter int BUDGET_CYC = 1000,
  parameter int POLL_CYC   = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic budget_clr,
  input  logic iv_load,
  output logic budget_over,
  output logic iv_done
);
  localparam int BW = $clog2(BUDGET_CYC + 1);
  localparam int IW = $clog2(POLL_CYC + 1);

  logic [BW-1:0] bcnt;
  logic [IW-1:0] icnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
    end else if (budget_clr) begin
      bcnt <= '0;
    end else if (bcnt != BW'(BUDGET_CYC)) begin
      bcnt <= bcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt <= '0;
    end else if (iv_load) begin
      icnt <= IW'(POLL_CYC - 1);
    end else if (icnt != '0) begin
      icnt <= icnt - 1'b1;
    end
  end

  assign budget_over = (bcnt == BW'(BUDGET_CYC));
  assign iv_done     = (icnt == '0);
endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
  import phy_pwr_pkg::*;
#(
  parameter int NLANE      = 4,
  parameter int BUDGET_CYC = 1000,
  parameter int POLL_CYC   = 20,
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 4,
  parameter int STAT_W     = 16,
  parameter int LOCK_ADDR  = 'h10,
  parameter int CLK_ADDR   = 'h12,
  parameter int CFG_VAL    = 'h8,
  parameter int LOCK_BIT   = 9,
  parameter int OUT_BIT    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLANE-1:0]  pwr_on_req,
  input  logic [NLANE-1:0]  pwr_off_req,
  output logic [NLANE-1:0]  req_done,
  output logic [1:0]        req_err,
  output logic              phy_reset,
  output logic [NLANE-1:0]  lane_idle,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  input  logic              rsp_valid,
  input  logic [STAT_W-1:0] rsp_data
);
  localparam int LANE_W = (NLANE > 1) ? $clog2(NLANE) : 1;
  localparam int CNT_W  = $clog2(NLANE + 1);

  seq_state_e        state;
  phase_e            phase;
  logic [CNT_W-1:0]  pwr_cnt;
  logic [LANE_W-1:0] cur_lane;

  logic              gnt_en, gnt_vld, gnt_on;
  logic [LANE_W-1:0] gnt_lane;
  logic              budget_clr, iv_load, budget_over, iv_done;
  logic              rsp_pass;
  logic [NLANE-1:0]  idle_set, idle_clr;

  function automatic logic [NLANE-1:0] lane_mask(input logic [LANE_W-1:0] l);
    return NLANE'(1) << l;
  endfunction

  assign gnt_en = (state == S_IDLE) && (req_done == '0);

  pwr_req_arb #(.NLANE(NLANE), .LANE_W(LANE_W)) u_arb (
    .en       (gnt_en),
    .on_req   (pwr_on_req),
    .off_req  (pwr_off_req),
    .gnt_vld  (gnt_vld),
    .gnt_lane (gnt_lane),
    .gnt_on   (gnt_on)
  );

  assign budget_clr = gnt_vld && gnt_on && (pwr_cnt == '0);
  assign iv_load    = (state == S_RSP) && rsp_valid && !rsp_pass;

  pwr_seq_timers #(.BUDGET_CYC(BUDGET_CYC), .POLL_CYC(POLL_CYC)) u_tmr (
    .clk         (clk),
    .rst_n       (rst_n),
    .budget_clr  (budget_clr),
    .iv_load     (iv_load),
    .budget_over (budget_over),
    .iv_done     (iv_done)
  );

  assign rsp_pass = (phase == PH_OUT) ? !rsp_data[OUT_BIT] : rsp_data[LOCK_BIT];

  // bridge request outputs follow the state directly
  assign cmd_valid = (state == S_SEL) || (state == S_WR_A) || (state == S_WR_B);
  assign cmd_write = (state == S_WR_A) || (state == S_WR_B);
  assign cmd_addr  = (state == S_WR_B) ? ADDR_W'(CLK_ADDR) : ADDR_W'(LOCK_ADDR);
  assign cmd_data  = (state == S_SEL) ? '0 : DATA_W'(CFG_VAL);
  assign rd_valid  = (state == S_RD);

  // idle bit strobes
  always_comb begin
    idle_set = '0;
    idle_clr = '0;
    if (gnt_vld && !gnt_on) begin
      idle_set = lane_mask(gnt_lane);
    end
    if (state == S_CHK && budget_over) begin
      idle_set = lane_mask(cur_lane);
    end
    if (state == S_SEL && cmd_ready && phase == PH_LOCK) begin
      idle_clr = lane_mask(cur_lane);
    end
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_idle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_idle[g] <= 1'b1;
      end else if (idle_set[g]) begin
        lane_idle[g] <= 1'b1;
      end else if (idle_clr[g]) begin
        lane_idle[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      phase     <= PH_LOCK;
      pwr_cnt   <= '0;
      cur_lane  <= '0;
      phy_reset <= 1'b1;
      req_done  <= '0;
      req_err   <= RES_OK;
    end else begin
      req_done <= '0;
      case (state)
        S_IDLE: begin
          if (gnt_vld) begin
            cur_lane <= gnt_lane;
            if (gnt_on) begin
              if (pwr_cnt == '0) begin
                pwr_cnt   <= CNT_W'(1);
                phy_reset <= 1'b0;
                phase     <= PH_LOCK;
                state     <= S_SEL;
              end else begin
                pwr_cnt  <= pwr_cnt + 1'b1;
                req_done <= lane_mask(gnt_lane);
                req_err  <= RES_OK;
              end
            end else begin
              if (pwr_cnt == CNT_W'(1)) begin
                phy_reset <= 1'b1;
              end
              if (pwr_cnt != '0) begin
                pwr_cnt <= pwr_cnt - 1'b1;
              end
              req_done <= lane_mask(gnt_lane);
              req_err  <= RES_OK;
            end
          end
        end
        S_SEL: begin
          if (cmd_ready) begin
            state <= S_CHK;
          end
        end
        S_WR_A: begin
          if (cmd_ready) begin
            state <= S_WR_B;
          end
        end
        S_WR_B: begin
          if (cmd_ready) begin
            phase <= PH_OUT;
            state <= S_CHK;
          end
        end
        S_CHK: begin
          if (budget_over) begin
            phy_reset <= 1'b1;
            pwr_cnt   <= pwr_cnt - 1'b1;
            req_done  <= lane_mask(cur_lane);
            req_err   <= (phase == PH_OUT) ? RES_OUTFLG : RES_LOCK;
            state     <= S_IDLE;
          end else begin
            state <= S_RD;
          end
        end
        S_RD: begin
          if (rd_ready) begin
            state <= S_RSP;
          end
        end
        S_RSP: begin
          if (rsp_valid) begin
            if (!rsp_pass) begin
              state <= S_GAP;
            end else begin
              case (phase)
                PH_LOCK: state <= S_WR_A;
                PH_OUT: begin
                  phase <= PH_RELOCK;
                  state <= S_SEL;
                end
                default: begin
                  req_done <= lane_mask(cur_lane);
                  req_err  <= RES_OK;
                  state    <= S_IDLE;
                end
              endcase
            end
          end
        end
        S_GAP: begin
          if (iv_done) begin
            state <= S_CHK;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phy_pwr_seq_chk.sv
module phy_pwr_seq_chk #(
  parameter int NLANE     = 4,
  parameter int POLL_CYC  = 20,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 4,
  parameter int LOCK_ADDR = 'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NLANE-1:0]  req_done,
  input logic [1:0]        req_err,
  input logic              phy_reset,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_write,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [DATA_W-1:0] cmd_data,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic              rsp_valid
);
  localparam int GW = $clog2(POLL_CYC + 2);

  logic          armed;
  logic [GW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      gap   <= '0;
    end else if (rsp_valid) begin
      armed <= 1'b1;
      gap   <= '0;
    end else if ((cmd_valid && cmd_ready) || req_done != '0) begin
      armed <= 1'b0;
    end else if (gap != GW'(POLL_CYC + 1)) begin
      gap <= gap + 1'b1;
    end
  end

  // R2
  bridge_idle_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid || rd_valid) |-> !phy_reset);

  // R3
  first_cmd_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phy_reset) |-> (cmd_valid && !cmd_write && cmd_addr == ADDR_W'(LOCK_ADDR)));

  // R5
  poll_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && armed) |-> (32'(gap) >= POLL_CYC - 1));

  // R7
  fail_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_done != '0 && req_err != 2'd0) |-> phy_reset);

  // R10
  done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_done));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_done != '0) |=> (req_done == '0));

  // R11
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable({cmd_write, cmd_addr, cmd_data})));

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid);
endmodule

bind phy_pwr_seq phy_pwr_seq_chk #(
  .NLANE(NLANE), .POLL_CYC(POLL_CYC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_ADDR(LOCK_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_done(req_done), .req_err(req_err), .phy_reset(phy_reset),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
  .cmd_data(cmd_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rsp_valid(rsp_valid)
);

// File: tb/tb_phy_pwr_seq.sv
module tb_phy_pwr_seq;
  localparam int NL = 4;
  localparam int BUDGET = 1000;
  localparam int POLL = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] pwr_on_req = '0, pwr_off_req = '0;
  logic [NL-1:0] req_done, lane_idle;
  logic [1:0]    req_err;
  logic          phy_reset, cmd_valid, cmd_write, rd_valid;
  logic          cmd_ready = 1'b1, rd_ready = 1'b1, rsp_valid = 1'b0;
  logic [5:0]    cmd_addr;
  logic [3:0]    cmd_data;
  logic [15:0]   rsp_data = '0;

  int nchk = 0, nerr = 0, cyc = 0;
  int ncmd = 0, nrd = 0, nrd_tot = 0, lk_n = 0, oe_n = 0, rl_n = 0;
  int last_rsp = 0, gap_bad = 0;
  bit armed = 0;
  logic [10:0] cmd_log [8];

  always #4 clk = ~clk;

  phy_pwr_seq #(.NLANE(NL), .BUDGET_CYC(BUDGET), .POLL_CYC(POLL)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
    .req_done(req_done), .req_err(req_err), .phy_reset(phy_reset), .lane_idle(lane_idle),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data)
  );

  // status word: bit 9 lock, bit 10 output flag; phase known from commands seen
  function automatic logic [15:0] stat_word(input int c, input int n);
    logic [15:0] s = 16'h0400;
    if (c == 1) s[9] = (lk_n != 0 && n >= lk_n);
    if (c == 3) s[10] = !(oe_n != 0 && n >= oe_n);
    if (c >= 4) begin s[10] = 1'b0; s[9] = (rl_n != 0 && n >= rl_n); end
    return s;
  endfunction

  // bridge model
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      rsp_valid <= 1'b0;
      if (rsp_valid) begin armed = 1; last_rsp = cyc; end
      if (cmd_valid && cmd_ready) begin
        if (ncmd < 8) cmd_log[ncmd] = {cmd_write, cmd_addr, cmd_data};
        ncmd++; nrd = 0; armed = 0;
      end
      if (rd_valid && rd_ready) begin
        if (armed && (cyc - last_rsp) < POLL) gap_bad++;
        nrd++; nrd_tot++;
        rsp_valid <= 1'b1;
        rsp_data  <= stat_word(ncmd, nrd);
      end
      if (req_done != '0) armed = 0;
      cmd_ready <= ((cyc % 4) != 1);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      lat++;
      if (req_done != '0) break;
    end
  endtask

  // {lane[24:23], on[22], lk[21:18], oe[17:14], rl[13:10], err[9:8], rst[7], idle[6:3], ncmd[2:0]}
  localparam logic [24:0] VEC [10] = '{
    {2'd0, 1'b1, 4'd2, 4'd2, 4'd2, 2'd0, 1'b0, 4'b1110, 3'd4},
    {2'd2, 1'b1, 4'd0, 4'd0, 4'd0, 2'd0, 1'b0, 4'b1110, 3'd0},
    {2'd0, 1'b0, 4'd0, 4'd0, 4'd0, 2'd0, 1'b0, 4'b1111, 3'd0},
    {2'd2, 1'b0, 4'd0, 4'd0, 4'd0, 2'd0, 1'b1, 4'b1111, 3'd0},
    {2'd1, 1'b1, 4'd0, 4'd1, 4'd1, 2'd1, 1'b1, 4'b1111, 3'd1},
    {2'd3, 1'b1, 4'd1, 4'd0, 4'd1, 2'd2, 1'b1, 4'b1111, 3'd3},
    {2'd3, 1'b1, 4'd1, 4'd1, 4'd0, 2'd1, 1'b1, 4'b1111, 3'd4},
    {2'd1, 1'b1, 4'd3, 4'd3, 4'd3, 2'd0, 1'b0, 4'b1101, 3'd4},
    {2'd1, 1'b0, 4'd0, 4'd0, 4'd0, 2'd0, 1'b1, 4'b1111, 3'd0},
    {2'd0, 1'b0, 4'd0, 4'd0, 4'd0, 2'd0, 1'b1, 4'b1111, 3'd0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    int lat;
    logic [24:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(phy_reset == 1'b1, "R1 reset", int'(phy_reset), 1);
    chk(lane_idle == 4'hF, "R1 idle", int'(lane_idle), 15);
    chk(req_done == '0 && !cmd_valid && !rd_valid, "R1 quiet", int'(req_done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(phy_reset == 1'b1 && lane_idle == 4'hF, "R1 after", int'(phy_reset), 1);

    for (int i = 0; i < 10; i++) begin
      v = VEC[i];
      lk_n = int'(v[21:18]); oe_n = int'(v[17:14]); rl_n = int'(v[13:10]);
      ncmd = 0; nrd = 0; nrd_tot = 0;
      if (v[22]) pwr_on_req[v[24:23]] = 1'b1; else pwr_off_req[v[24:23]] = 1'b1;
      wait_done(lat);
      pwr_on_req = '0; pwr_off_req = '0;
      chk(req_done == (4'b1 << v[24:23]), "R10 done lane", int'(req_done), 1 << v[24:23]);
      chk(req_err == v[9:8], v[9:8] != 0 ? "R7 result" : "R2 R8 result", int'(req_err), int'(v[9:8]));
      chk(phy_reset == v[7], v[22] ? "R2 R7 reset" : "R8 reset", int'(phy_reset), int'(v[7]));
      chk(lane_idle == v[6:3], v[22] ? "R3 R7 idle" : "R8 idle", int'(lane_idle), int'(v[6:3]));
      chk(ncmd == int'(v[2:0]), "R3 cmd count", ncmd, int'(v[2:0]));
      if (v[9:8] != 0) begin
        chk(lat >= BUDGET && lat <= BUDGET + POLL + 40, "R6 budget", lat, BUDGET);
      end
      if (v[9:8] == 0 && v[2:0] == 3'd4) begin
        chk(nrd_tot == lk_n + oe_n + rl_n, "R4 poll reads", nrd_tot, lk_n + oe_n + rl_n);
      end
      if (i == 0) begin
        chk(cmd_log[0] == {1'b0, 6'h10, 4'h0}, "R3 cmd0", int'(cmd_log[0]), 'h100);
        chk(cmd_log[1] == {1'b1, 6'h10, 4'h8}, "R3 cmd1", int'(cmd_log[1]), 'h508);
        chk(cmd_log[2] == {1'b1, 6'h12, 4'h8}, "R3 cmd2", int'(cmd_log[2]), 'h528);
        chk(cmd_log[3] == {1'b0, 6'h10, 4'h0}, "R3 cmd3", int'(cmd_log[3]), 'h100);
      end
    end

    // R9: lanes 3 and 0 together, lane 0 first
    lk_n = 1; oe_n = 1; rl_n = 1; ncmd = 0;
    @(negedge clk);
    pwr_on_req = 4'b1001;
    wait_done(lat);
    chk(req_done == 4'b0001, "R9 priority", int'(req_done), 1);
    pwr_on_req[0] = 1'b0;
    chk(ncmd == 4, "R9 first runs sequence", ncmd, 4);
    ncmd = 0;
    wait_done(lat);
    chk(req_done == 4'b1000, "R9 second", int'(req_done), 8);
    pwr_on_req = '0;
    chk(ncmd == 0 && lane_idle == 4'b1110, "R2 later on no traffic", ncmd, 0);
    // R9: on and off together on lane 2 -> on served
    pwr_on_req[2] = 1'b1; pwr_off_req[2] = 1'b1;
    wait_done(lat);
    pwr_on_req = '0; pwr_off_req = '0;
    chk(lane_idle == 4'b1110 && ncmd == 0, "R9 on wins", int'(lane_idle), 'he);
    // three offs: reset only after the last (count 3)
    for (int j = 0; j < 3; j++) begin
      pwr_off_req[j == 0 ? 0 : (j == 1 ? 3 : 2)] = 1'b1;
      wait_done(lat);
      pwr_off_req = '0;
      chk(phy_reset == (j == 2), "R8 count to zero", int'(phy_reset), int'(j == 2));
    end
    chk(gap_bad == 0, "R5 poll spacing", gap_bad, 0);

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule